// File: doc/BRIEF.md
# Relocatable RAM and Register-Block Window Decoder

This block decodes a 16-bit CPU address into two chip selects: one for a 1 KB internal RAM and one for a 96-byte peripheral register block. The location of each window is not a fixed constant. It comes from a one-byte placement register. The high nibble of that register supplies address bits 15:12 of the RAM base. The low nibble supplies address bits 15:12 of the register-block base. Either window can therefore sit on any 4 KB boundary. Alongside each select the block gives the local offset inside the window. The placement register is always visible on a read-back output.

The placement register is written through the register block itself, at local offset 0x3D, so software moves the windows by writing into the window it already sees. A guard state machine protects the register with three states. GS_OPEN is entered on reset. GS_WRITTEN is entered from GS_OPEN when a normal-mode write is accepted. GS_EXPIRED is entered from GS_OPEN when the 64th cycle after reset release passes without an accepted write. Both GS_WRITTEN and GS_EXPIRED are left only by reset. When the special-mode input is high, every write is accepted whatever the state is, and those writes do not move the state machine.

Top module: `memmap_window_dec`

## Requirements
- R1: After reset, map_q reads 0x01, so the RAM decodes at 0x0000–0x03FF and the register block decodes at 0x1000–0x105F.
- R2: ram_sel is high when addr[15:12] equals map_q[7:4] and addr[11:0] is below 0x400, unless R4 applies. ram_ofs always equals addr[9:0].
- R3: reg_sel is high exactly when addr[15:12] equals map_q[3:0] and addr[11:0] is below 0x060. reg_ofs always equals addr[6:0].
- R4: When an address falls inside both windows, reg_sel is high and ram_sel is low.
- R5: A write is a cycle with wr_en high while reg_sel is high and reg_ofs equals 0x3D. If accepted, wr_data appears on map_q after that clock edge, and the decode uses it from the next cycle on. A wr_en cycle at any other address leaves map_q unchanged.
- R6: In normal mode (special_mode low), the first write at clock edges 0 through 63 after reset release is accepted. Every later normal-mode write is ignored.
- R7: In normal mode, a write at clock edge 64 or later after reset release is ignored, even if no earlier write was accepted.
- R8: With special_mode high, every write is accepted at any time, any number of times.
- R9: Writes made with special_mode high do not use up the single normal-mode write. A normal-mode write inside the 64-cycle window is still accepted afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| special_mode | input | 1 | High: placement register writable at any time |
| addr | input | 16 | CPU address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| ram_sel | output | 1 | RAM window select |
| ram_ofs | output | 10 | Offset inside the RAM window |
| reg_sel | output | 1 | Register-block window select |
| reg_ofs | output | 7 | Offset inside the register block |
| map_q | output | 8 | Current placement register |

## Verification
Two events can land on the same clock edge: the last cycle of the write window and an incoming write. At edge 63 the guard must accept the write even though it is also moving out of GS_OPEN. At edge 64 it must refuse the write. Each case is provoked from a fresh reset by idling for exactly 63 or 64 edges before writing. It is judged by map_q and by the decode one cycle after the write. A second collision happens when both windows are placed on one page. The decode is then probed below and above offset 0x060 to confirm that the register block wins and that the RAM returns beyond it.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

    // Write-guard states for the placement register
    typedef enum logic [1:0] {
        GS_OPEN    = 2'd0,
        GS_WRITTEN = 2'd1,
        GS_EXPIRED = 2'd2
    } guard_state_e;

endpackage

// File: rtl/page_window.sv
// One relocatable window: a 4 KB page selector plus a span check on the low bits.
module page_window #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 4,
    parameter int SPAN   = 1024,
    localparam int LOW_W = ADDR_W - PAGE_W,
    localparam int OFS_W = $clog2(SPAN)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [PAGE_W-1:0] page,
    output logic              hit,
    output logic [OFS_W-1:0]  ofs
);

    logic page_match;
    logic in_span;

    always_comb begin
        page_match = (addr[ADDR_W-1 -: PAGE_W] == page);
        in_span    = (addr[LOW_W-1:0] < LOW_W'(SPAN));
        hit        = page_match && in_span;
        ofs        = addr[OFS_W-1:0];
    end

endmodule

// File: rtl/wr_guard.sv
// Post-reset window counter and write-acceptance state machine.
module wr_guard
    import memmap_pkg::*;
#(
    parameter int OPEN_CYCLES = 64,
    localparam int CNT_W = $clog2(OPEN_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic special_mode,
    input  logic wr_hit,
    output logic wr_accept
);

    localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(OPEN_CYCLES - 1);
    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(OPEN_CYCLES);

    logic [CNT_W-1:0] cyc_cnt;
    guard_state_e     state_q;
    guard_state_e     state_d;

    // Saturating count of edges since reset release
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_cnt <= '0;
        end else if (cyc_cnt != CNT_LIMIT) begin
            cyc_cnt <= cyc_cnt + 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_OPEN: begin
                if (wr_hit && !special_mode) begin
                    state_d = GS_WRITTEN;
                end else if (cyc_cnt == CNT_LAST) begin
                    state_d = GS_EXPIRED;
                end
            end
            GS_WRITTEN: state_d = GS_WRITTEN;
            GS_EXPIRED: state_d = GS_EXPIRED;
            default:    state_d = GS_EXPIRED;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GS_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    // Output logic
    always_comb begin
        wr_accept = 1'b0;
        unique case (state_q)
            GS_OPEN:    wr_accept = wr_hit;
            GS_WRITTEN: wr_accept = wr_hit && special_mode;
            GS_EXPIRED: wr_accept = wr_hit && special_mode;
            default:    wr_accept = 1'b0;
        endcase
    end

endmodule

// File: rtl/map_register.sv
// Placement register holding both page nibbles.
module map_register #(
    parameter int         W       = 8,
    parameter logic [W-1:0] RST_VAL = 8'h01
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/memmap_window_dec.sv
module memmap_window_dec
    import memmap_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int PAGE_W      = 4,
    parameter int RAM_SPAN    = 1024,
    parameter int REG_SPAN    = 96,
    parameter int OPEN_CYCLES = 64,
    parameter int MAP_OFS     = 'h3D,
    parameter int MAP_RST     = 'h01,
    localparam int MAP_W      = 2 * PAGE_W,
    localparam int RAM_OFS_W  = $clog2(RAM_SPAN),
    localparam int REG_OFS_W  = $clog2(REG_SPAN)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 special_mode,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr_en,
    input  logic [MAP_W-1:0]     wr_data,
    output logic                 ram_sel,
    output logic [RAM_OFS_W-1:0] ram_ofs,
    output logic                 reg_sel,
    output logic [REG_OFS_W-1:0] reg_ofs,
    output logic [MAP_W-1:0]     map_q
);

    logic                 ram_hit;
    logic                 reg_hit;
    logic [RAM_OFS_W-1:0] ram_o;
    logic [REG_OFS_W-1:0] reg_o;
    logic                 wr_hit;
    logic                 wr_accept;

    // RAM window: page from the high nibble
    page_window #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W),
        .SPAN   (RAM_SPAN)
    ) ram_win_i (
        .addr (addr),
        .page (map_q[MAP_W-1 -: PAGE_W]),
        .hit  (ram_hit),
        .ofs  (ram_o)
    );

    // Register-block window: page from the low nibble
    page_window #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W),
        .SPAN   (REG_SPAN)
    ) reg_win_i (
        .addr (addr),
        .page (map_q[PAGE_W-1:0]),
        .hit  (reg_hit),
        .ofs  (reg_o)
    );

    // Register block has priority on overlap
    always_comb begin
        reg_sel = reg_hit;
        ram_sel = ram_hit && !reg_hit;
        ram_ofs = ram_o;
        reg_ofs = reg_o;
        wr_hit  = wr_en && reg_hit && (reg_o == REG_OFS_W'(MAP_OFS));
    end

    wr_guard #(
        .OPEN_CYCLES (OPEN_CYCLES)
    ) guard_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .special_mode (special_mode),
        .wr_hit       (wr_hit),
        .wr_accept    (wr_accept)
    );

    map_register #(
        .W       (MAP_W),
        .RST_VAL (MAP_W'(MAP_RST))
    ) map_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wr_accept),
        .d     (wr_data),
        .q     (map_q)
    );

endmodule

// File: rtl/memmap_window_dec_chk.sv
module memmap_window_dec_chk #(
    parameter int OPEN_CYCLES = 64,
    parameter int MAP_OFS     = 'h3D
) (
    input logic        clk,
    input logic        rst_n,
    input logic        special_mode,
    input logic [15:0] addr,
    input logic        wr_en,
    input logic [7:0]  wr_data,
    input logic        ram_sel,
    input logic        reg_sel,
    input logic [6:0]  reg_ofs,
    input logic [7:0]  map_q
);

    localparam int CW = $clog2(OPEN_CYCLES + 1);

    logic [CW-1:0] cyc;
    logic          normal_taken;
    logic          map_write;

    assign map_write = wr_en && reg_sel && (reg_ofs == 7'(MAP_OFS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc          <= '0;
            normal_taken <= 1'b0;
        end else begin
            if (cyc != CW'(OPEN_CYCLES)) cyc <= cyc + 1'b1;
            if (map_write && !special_mode && (cyc < CW'(OPEN_CYCLES)))
                normal_taken <= 1'b1;
        end
    end

    AST_RAM_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        ram_sel |-> (addr[15:12] == map_q[7:4] && addr[11:10] == 2'b00)); // R2
    AST_REG_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel |-> (addr[15:12] == map_q[3:0] && addr[11:0] < 12'h060)); // R3
    AST_NO_DOUBLE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_sel && reg_sel)); // R4
    AST_SECOND_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (normal_taken && !special_mode) |=> $stable(map_q)); // R6
    AST_LATE_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CW'(OPEN_CYCLES) && !special_mode) |=> $stable(map_q)); // R7
    AST_SPECIAL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (special_mode && map_write) |=> (map_q == $past(wr_data))); // R8

endmodule

bind memmap_window_dec memmap_window_dec_chk #(
    .OPEN_CYCLES (OPEN_CYCLES),
    .MAP_OFS     (MAP_OFS)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .special_mode (special_mode),
    .addr         (addr),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .ram_sel      (ram_sel),
    .reg_sel      (reg_sel),
    .reg_ofs      (reg_ofs),
    .map_q        (map_q)
);

// File: tb/memmap_window_dec_tb_top.sv
`timescale 1ns/1ps
module memmap_window_dec_tb_top;

    localparam int WATCHDOG = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        special_mode = 1'b0;
    logic [15:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        ram_sel;
    logic [9:0]  ram_ofs;
    logic        reg_sel;
    logic [6:0]  reg_ofs;
    logic [7:0]  map_q;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    memmap_window_dec dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .special_mode (special_mode),
        .addr         (addr),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .ram_sel      (ram_sel),
        .ram_ofs      (ram_ofs),
        .reg_sel      (reg_sel),
        .reg_ofs      (reg_ofs),
        .map_q        (map_q)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        special_mode = 1'b0;
        addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;   // next rising edge is edge 0
    endtask

    // Issue a write on edge k counted from the current negedge
    task automatic write_at(input int k, input logic [15:0] a, input logic [7:0] d);
        repeat (k) @(negedge clk);
        addr = a;
        wr_data = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic probe(input string req, input logic [15:0] a,
                         input logic exp_ram, input logic exp_reg);
        addr = a;
        #1;
        check(req, $sformatf("ram_sel@%h", a), 32'(ram_sel), 32'(exp_ram));
        check(req, $sformatf("reg_sel@%h", a), 32'(reg_sel), 32'(exp_reg));
    endtask

    task automatic t_reset_state();
        do_reset();
        #1;
        check("R1", "map_q", 32'(map_q), 32'h01);
        probe("R1", 16'h0000, 1'b1, 1'b0);
        probe("R2", 16'h03FF, 1'b1, 1'b0);
        check("R2", "ram_ofs", 32'(ram_ofs), 32'h3FF);
        probe("R2", 16'h0400, 1'b0, 1'b0);
        probe("R1", 16'h1000, 1'b0, 1'b1);
        probe("R3", 16'h105F, 1'b0, 1'b1);
        check("R3", "reg_ofs", 32'(reg_ofs), 32'h5F);
        probe("R3", 16'h1060, 1'b0, 1'b0);
    endtask

    task automatic t_normal_once();
        do_reset();
        addr = 16'h103D;
        #1;
        check("R5", "old decode before write edge", 32'(reg_sel), 32'h1);
        @(negedge clk);
        write_at(0, 16'h103D, 8'h2F);
        #1;
        check("R5", "map_q after write", 32'(map_q), 32'h2F);
        probe("R5", 16'h2100, 1'b1, 1'b0);
        check("R2", "ram_ofs moved", 32'(ram_ofs), 32'h100);
        probe("R5", 16'hF03D, 1'b0, 1'b1);
        probe("R5", 16'h103D, 1'b0, 1'b0);
        write_at(1, 16'hF03D, 8'h55);
        #1;
        check("R6", "second normal write ignored", 32'(map_q), 32'h2F);
    endtask

    task automatic t_wrong_target();
        do_reset();
        write_at(0, 16'h103C, 8'h33);
        #1;
        check("R5", "other offset ignored", 32'(map_q), 32'h01);
        write_at(0, 16'h203D, 8'h33);
        #1;
        check("R5", "outside block ignored", 32'(map_q), 32'h01);
        write_at(0, 16'h103D, 8'h44);
        #1;
        check("R6", "first real write accepted", 32'(map_q), 32'h44);
    endtask

    task automatic t_window_edge();
        do_reset();
        write_at(63, 16'h103D, 8'h30);
        #1;
        check("R6", "write at edge 63", 32'(map_q), 32'h30);
        do_reset();
        write_at(64, 16'h103D, 8'h30);
        #1;
        check("R7", "write at edge 64", 32'(map_q), 32'h01);
        probe("R7", 16'h0000, 1'b1, 1'b0);
        write_at(20, 16'h103D, 8'h77);
        #1;
        check("R7", "much later write", 32'(map_q), 32'h01);
    endtask

    task automatic t_overlap();
        do_reset();
        write_at(0, 16'h103D, 8'h33);
        probe("R4", 16'h3010, 1'b0, 1'b1);
        probe("R4", 16'h305F, 1'b0, 1'b1);
        probe("R4", 16'h3060, 1'b1, 1'b0);
        probe("R4", 16'h33FF, 1'b1, 1'b0);
    endtask

    task automatic t_special();
        do_reset();
        special_mode = 1'b1;
        write_at(100, 16'h103D, 8'h45);
        #1;
        check("R8", "late special write", 32'(map_q), 32'h45);
        write_at(0, 16'h503D, 8'h67);
        #1;
        check("R8", "repeat special write", 32'(map_q), 32'h67);
        special_mode = 1'b0;
        write_at(0, 16'h703D, 8'h11);
        #1;
        check("R7", "normal after expiry", 32'(map_q), 32'h67);
    endtask

    task automatic t_special_then_normal();
        do_reset();
        special_mode = 1'b1;
        write_at(0, 16'h103D, 8'h12);
        special_mode = 1'b0;
        #1;
        check("R8", "special write in window", 32'(map_q), 32'h12);
        write_at(1, 16'h203D, 8'h34);
        #1;
        check("R9", "normal write after special", 32'(map_q), 32'h34);
        write_at(0, 16'h403D, 8'h56);
        #1;
        check("R6", "then locked", 32'(map_q), 32'h34);
    endtask

    initial begin
        t_reset_state();
        t_normal_once();
        t_wrong_target();
        t_window_edge();
        t_overlap();
        t_special();
        t_special_then_normal();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog all actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule